// File: doc/BRIEF.md
# Uncore Event Counter Unit

This unit sits beside a memory-access controller and counts events from it. It has eight independent 64-bit counters. Each counter picks one line out of a bank of 256 event-pulse inputs using an 8-bit selector code. Software reaches every piece of state through a simple single-cycle register port with 64-bit words. Through that port it presets and reads the counters and programs each counter's event code. It switches counting and interrupts on and off per counter through paired set and clear registers. It collects counter wraparounds from an overflow status register.

The register port has no handshake. A write is accepted on every rising edge where `wr_en` is high. Read data is a combinational function of `addr`, so the port never applies back-pressure. A global control word gates all counting and has a self-clearing reset bit. The `irq` output is a level. It stays high while any overflow bit is set whose interrupt enable is also set.

Top module: `evcnt_unit`

## Requirements
- R1: After `rst_n` is released, all counters, counter enables, interrupt enables, overflow bits, event codes and the global enable read zero, and `irq` is low.
- R2: Register addresses (all 8-byte aligned, bits [2:0] zero). Counter n is at 0x000+8n, control word n is at 0x100+8n and event code n is at 0x200+8n. The global control is at 0x400, counter-enable set/clear are at 0x410/0x418, interrupt-enable set/clear are at 0x420/0x428, and the overflow status is at 0x440. Reads are combinational in the same cycle. Writes take effect at the rising edge.
- R3: Counter n adds 1 at a rising edge only when global enable (control bit 0), its counter-enable bit n and `events[code n]` are all 1. Otherwise it holds.
- R4: Event code 0x00 counts every cycle whatever `events[0]` is.
- R5: The event-code register keeps only the low 8 bits of a write. Its upper bits read zero.
- R6: Writing 1 to bit n at 0x410 (0x420) sets counter-enable (interrupt-enable) n. Writing 1 to bit n at 0x418 (0x428) clears it. Zero bits have no effect. Reading the set or the clear address returns the current mask in bits [7:0].
- R7: A write to a counter loads the written value. In a cycle where the same counter would also increment, the written value wins.
- R8: When a counter increments from all ones to zero, its bit in the overflow status (bit n = counter n) is set. Writing 1 to a status bit clears it. If a wrap and a clear of the same bit fall at the same edge, the bit ends set.
- R9: `irq` is high exactly while some overflow bit n and interrupt-enable bit n are both 1.
- R10: A control write with bit 1 set clears all counters, counter enables, interrupt enables and overflow bits at that edge. Bit 0 of the same write becomes the global enable. Bit 1 always reads 0.
- R11: Control word n keeps the low 8 bits of a write and reads them back. It has no effect on counting.
- R12: Unmapped or misaligned addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 12 | Byte address of the register |
| wdata | input | 64 | Write data |
| events | input | 256 | Event pulse lines, indexed by event code |
| rdata | output | 64 | Read data for `addr`, same cycle |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of actions can land on the same edge: a counter wrap setting its overflow bit while software write-one-clears that bit, and a counter preset while that counter increments. The bench sets up the first pair by holding a counter at all ones with its event line low. It then raises the event line for exactly the edge that carries the overflow-clear write, and expects the bit to stay set and the count to read zero. The second pair is judged by a preset written while code 0x00 is counting, where the count after the next edge must be the preset plus one.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

  localparam int AW = 12;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CNT,
    RK_CTL,
    RK_TYP,
    RK_GCTL,
    RK_EN,
    RK_IE,
    RK_OV
  } rkind_e;

  localparam logic [AW-1:0] A_CNT  = 12'h000;
  localparam logic [AW-1:0] A_CTL  = 12'h100;
  localparam logic [AW-1:0] A_TYP  = 12'h200;
  localparam logic [AW-1:0] A_GCTL = 12'h400;
  localparam logic [AW-1:0] A_ENS  = 12'h410;
  localparam logic [AW-1:0] A_ENC  = 12'h418;
  localparam logic [AW-1:0] A_IES  = 12'h420;
  localparam logic [AW-1:0] A_IEC  = 12'h428;
  localparam logic [AW-1:0] A_OVS  = 12'h440;

  localparam int GC_EN_BIT  = 0;
  localparam int GC_RST_BIT = 1;

endpackage

// File: rtl/evcnt_regdec.sv
module evcnt_regdec
  import evcnt_pkg::*;
#(
  parameter int NCNT = 8
) (
  input  logic [AW-1:0]           addr,
  input  logic                    wr_en,
  output rkind_e                  kind,
  output logic [$clog2(NCNT)-1:0] idx,
  output logic [NCNT-1:0]         cnt_we,
  output logic [NCNT-1:0]         ctl_we,
  output logic [NCNT-1:0]         typ_we,
  output logic                    gctl_we,
  output logic                    ens_we,
  output logic                    enc_we,
  output logic                    ies_we,
  output logic                    iec_we,
  output logic                    ovs_we
);
  localparam int IW  = $clog2(NCNT);
  localparam int LSB = IW + 3;

  logic aligned;
  logic in_range;

  assign aligned  = (addr[2:0] == 3'b000);
  assign idx      = addr[LSB-1:3];
  assign in_range = (int'(idx) < NCNT);

  always_comb begin
    kind = RK_NONE;
    if (aligned) begin
      if (addr[AW-1:LSB] == A_CNT[AW-1:LSB] && in_range)      kind = RK_CNT;
      else if (addr[AW-1:LSB] == A_CTL[AW-1:LSB] && in_range) kind = RK_CTL;
      else if (addr[AW-1:LSB] == A_TYP[AW-1:LSB] && in_range) kind = RK_TYP;
      else if (addr == A_GCTL)                                kind = RK_GCTL;
      else if (addr == A_ENS || addr == A_ENC)                kind = RK_EN;
      else if (addr == A_IES || addr == A_IEC)                kind = RK_IE;
      else if (addr == A_OVS)                                 kind = RK_OV;
    end
  end

  for (genvar n = 0; n < NCNT; n++) begin : g_we
    assign cnt_we[n] = wr_en && (kind == RK_CNT) && (idx == IW'(n));
    assign ctl_we[n] = wr_en && (kind == RK_CTL) && (idx == IW'(n));
    assign typ_we[n] = wr_en && (kind == RK_TYP) && (idx == IW'(n));
  end

  assign gctl_we = wr_en && aligned && (addr == A_GCTL);
  assign ens_we  = wr_en && aligned && (addr == A_ENS);
  assign enc_we  = wr_en && aligned && (addr == A_ENC);
  assign ies_we  = wr_en && aligned && (addr == A_IES);
  assign iec_we  = wr_en && aligned && (addr == A_IEC);
  assign ovs_we  = wr_en && aligned && (addr == A_OVS);

endmodule

// File: rtl/evcnt_w1mask.sv
module evcnt_w1mask #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wipe,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  logic [W-1:0] set_m;
  logic [W-1:0] clr_m;

  assign set_m = set_we ? bits : '0;
  assign clr_m = clr_we ? bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (wipe) q <= '0;
    else           q <= (q | set_m) & ~clr_m;
  end

endmodule

// File: rtl/evcnt_counter.sv
module evcnt_counter #(
  parameter int CW = 64,
  parameter int SW = 8,
  parameter int TW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wipe,
  input  logic            run,
  input  logic [2**SW-1:0] ev,
  input  logic            load,
  input  logic            typ_we,
  input  logic            ctl_we,
  input  logic [CW-1:0]   wdata,
  output logic [CW-1:0]   cnt,
  output logic [SW-1:0]   sel,
  output logic [TW-1:0]   ctl,
  output logic            wrap
);
  logic ev_hit;
  logic step;

  // code zero is the free-running cycle count
  assign ev_hit = (sel == '0) ? 1'b1 : ev[sel];
  assign step   = run & ev_hit;
  assign wrap   = step & (&cnt) & ~load & ~wipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wipe) cnt <= '0;
    else if (load) cnt <= wdata;
    else if (step) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
      ctl <= '0;
    end else begin
      if (typ_we) sel <= wdata[SW-1:0];
      if (ctl_we) ctl <= wdata[TW-1:0];
    end
  end

endmodule

// File: rtl/evcnt_unit.sv
module evcnt_unit
  import evcnt_pkg::*;
#(
  parameter int NCNT = 8,
  parameter int CW   = 64,
  parameter int DW   = 64,
  parameter int SW   = 8,
  parameter int TW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [2**SW-1:0]  events,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  localparam int IW = $clog2(NCNT);

  rkind_e                     kind;
  logic [IW-1:0]              idx;
  logic [NCNT-1:0]            cnt_we, ctl_we, typ_we;
  logic                       gctl_we, ens_we, enc_we, ies_we, iec_we, ovs_we;
  logic                       gen_en;
  logic                       sw_rst;
  logic [NCNT-1:0]            cnt_en, int_en, ovf, wrap;
  logic [NCNT-1:0][CW-1:0]    cnt_q;
  logic [NCNT-1:0][SW-1:0]    sel_q;
  logic [NCNT-1:0][TW-1:0]    ctl_q;
  logic [NCNT-1:0]            ov_ack;

  evcnt_regdec #(.NCNT(NCNT)) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .kind    (kind),
    .idx     (idx),
    .cnt_we  (cnt_we),
    .ctl_we  (ctl_we),
    .typ_we  (typ_we),
    .gctl_we (gctl_we),
    .ens_we  (ens_we),
    .enc_we  (enc_we),
    .ies_we  (ies_we),
    .iec_we  (iec_we),
    .ovs_we  (ovs_we)
  );

  assign sw_rst = gctl_we & wdata[GC_RST_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gen_en <= 1'b0;
    else if (gctl_we) gen_en <= wdata[GC_EN_BIT];
  end

  evcnt_w1mask #(.W(NCNT)) u_cnt_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wipe   (sw_rst),
    .set_we (ens_we),
    .clr_we (enc_we),
    .bits   (wdata[NCNT-1:0]),
    .q      (cnt_en)
  );

  evcnt_w1mask #(.W(NCNT)) u_int_en (
    .clk    (clk),
    .rst_n  (rst_n),
    .wipe   (sw_rst),
    .set_we (ies_we),
    .clr_we (iec_we),
    .bits   (wdata[NCNT-1:0]),
    .q      (int_en)
  );

  for (genvar n = 0; n < NCNT; n++) begin : g_cnt
    evcnt_counter #(.CW(CW), .SW(SW), .TW(TW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wipe   (sw_rst),
      .run    (gen_en & cnt_en[n]),
      .ev     (events),
      .load   (cnt_we[n]),
      .typ_we (typ_we[n]),
      .ctl_we (ctl_we[n]),
      .wdata  (wdata[CW-1:0]),
      .cnt    (cnt_q[n]),
      .sel    (sel_q[n]),
      .ctl    (ctl_q[n]),
      .wrap   (wrap[n])
    );
  end

  // a wrap at the same edge as its acknowledge keeps the bit set
  assign ov_ack = ovs_we ? wdata[NCNT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovf <= '0;
    else if (sw_rst) ovf <= '0;
    else             ovf <= (ovf & ~ov_ack) | wrap;
  end

  assign irq = |(ovf & int_en);

  always_comb begin
    unique case (kind)
      RK_CNT:  rdata = DW'(cnt_q[idx]);
      RK_CTL:  rdata = DW'(ctl_q[idx]);
      RK_TYP:  rdata = DW'(sel_q[idx]);
      RK_GCTL: rdata = DW'(gen_en);
      RK_EN:   rdata = DW'(cnt_en);
      RK_IE:   rdata = DW'(int_en);
      RK_OV:   rdata = DW'(ovf);
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/evcnt_sva.sv
module evcnt_sva
  import evcnt_pkg::*;
#(
  parameter int NCNT = 8,
  parameter int CW   = 64
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [AW-1:0]        addr,
  input logic [NCNT-1:0]      wdata_lo,
  input logic                 irq,
  input logic                 gen_en,
  input logic [NCNT-1:0]      cnt_en,
  input logic [NCNT-1:0]      int_en,
  input logic [NCNT-1:0]      ovf,
  input logic [NCNT-1:0][CW-1:0] cnt_q
);

  p_sw_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_GCTL && wdata_lo[GC_RST_BIT])
      |=> (cnt_en == '0 && int_en == '0 && ovf == '0 && !irq));

  p_en_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ENS) |=> (cnt_en == ($past(cnt_en) | $past(wdata_lo))));

  p_ie_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IEC) |=> (int_en == ($past(int_en) & ~$past(wdata_lo))));

  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !wr_en) |=> $stable(cnt_q));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !irq);

  for (genvar n = 0; n < NCNT; n++) begin : g_ov
    p_ov_on_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[n]) |-> (cnt_q[n] == '0));
  end

endmodule

bind evcnt_unit evcnt_sva #(.NCNT(NCNT), .CW(CW)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata_lo (wdata[NCNT-1:0]),
  .irq      (irq),
  .gen_en   (gen_en),
  .cnt_en   (cnt_en),
  .int_en   (int_en),
  .ovf      (ovf),
  .cnt_q    (cnt_q)
);

// File: tb/tb_evcnt_unit.sv
`timescale 1ns/100ps
module tb_evcnt_unit;
  import evcnt_pkg::*;

  localparam int NCNT = 8;
  localparam int NEV  = 256;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [11:0]     addr = '0;
  logic [63:0]     wdata = '0;
  logic [NEV-1:0]  events = '0;
  logic [63:0]     rdata;
  logic            irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evcnt_unit dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .events (events),
    .rdata  (rdata),
    .irq    (irq)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // one write, one rising edge; returns at the following falling edge
  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    addr = a;
    #0.1;
    d = rdata;
  endtask

  // count window: n idle edges plus the edge of the disabling write
  task automatic run(input int n);
    wr(A_GCTL, 64'h1);
    repeat (n) @(negedge clk);
    wr(A_GCTL, 64'h0);
  endtask

  function automatic logic [63:0] exp_cnt(logic [63:0] pre, bit en, logic [7:0] code,
                                          logic [NEV-1:0] ev, int n);
    bit hit;
    hit = en && ((code == 8'h00) || ev[code]);
    return hit ? pre + 64'(n + 1) : pre;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < NCNT; k++) begin
      rd(A_CNT + 12'(8*k), v); chk("R1 counter zero", v, 64'h0);
    end
    @(negedge clk);
    rd(A_ENS, v);  chk("R1 enables zero", v, 64'h0);
    rd(A_IES, v);  chk("R1 int enables zero", v, 64'h0);
    rd(A_OVS, v);  chk("R1 overflow zero", v, 64'h0);
    rd(A_GCTL, v); chk("R1 global zero", v, 64'h0);
    rd(A_TYP + 12'h8, v); chk("R1 event code zero", v, 64'h0);
    chk("R1 irq low", 64'(irq), 64'h0);
    @(negedge clk);

    // R5 / R11 field widths
    wr(A_TYP + 12'h10, 64'hFFFF_FFFF_0000_ABCD);
    rd(A_TYP + 12'h10, v); chk("R5 code low byte", v, 64'hCD);
    wr(A_CTL + 12'h08, 64'h1234);
    rd(A_CTL + 12'h08, v); chk("R11 control word", v, 64'h34);
    wr(A_TYP + 12'h10, 64'h0);

    // R12 unmapped / misaligned
    rd(12'h500, v); chk("R12 unmapped read", v, 64'h0);
    rd(12'h404, v); chk("R12 misaligned read", v, 64'h0);
    wr(12'h600, 64'hFF);
    wr(12'h412, 64'hFF);
    rd(A_ENS, v); chk("R12 write ignored", v, 64'h0);

    // R6 set / clear masks
    wr(A_ENS, 64'h05); wr(A_ENS, 64'h02);
    rd(A_ENS, v); chk("R6 set accumulates", v, 64'h07);
    wr(A_ENC, 64'h04);
    rd(A_ENC, v); chk("R6 clear via clear addr", v, 64'h03);
    wr(A_IES, 64'hF0); wr(A_IEC, 64'h30);
    rd(A_IES, v); chk("R6 int mask", v, 64'hC0);
    wr(A_IEC, 64'hFF); wr(A_ENC, 64'hFF);

    // R3 / R4 directed: code 0 counts with events[0] low
    events = '0;
    for (int k = 0; k < NCNT; k++) wr(A_CNT + 12'(8*k), 64'h0);
    wr(A_TYP + 12'h00, 64'h00);
    wr(A_TYP + 12'h08, 64'h07);
    wr(A_TYP + 12'h18, 64'h00);
    wr(A_ENS, 64'h03);
    run(9);
    rd(A_CNT + 12'h00, v); chk("R4 code zero counts", v, 64'd10);
    rd(A_CNT + 12'h08, v); chk("R3 idle event holds", v, 64'd0);
    rd(A_CNT + 12'h18, v); chk("R3 disabled holds", v, 64'd0);

    // R3 / R2 random windows
    for (int it = 0; it < 6; it++) begin
      logic [63:0] pre [NCNT];
      logic [7:0]  code [NCNT];
      logic [7:0]  msk;
      int          n;
      for (int w = 0; w < NEV/32; w++) events[w*32 +: 32] = $urandom;
      msk = 8'($urandom);
      n = 1 + int'($urandom % 50);
      wr(A_ENC, 64'hFF);
      wr(A_ENS, 64'(msk));
      for (int k = 0; k < NCNT; k++) begin
        code[k] = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
        pre[k]  = 64'($urandom % 65536);
        wr(A_CNT + 12'(8*k), pre[k]);
        wr(A_TYP + 12'(8*k), 64'(code[k]));
      end
      run(n);
      for (int k = 0; k < NCNT; k++) begin
        rd(A_CNT + 12'(8*k), v);
        chk("R3 R2 random count", v, exp_cnt(pre[k], msk[k], code[k], events, n));
      end
      @(negedge clk);
    end
    events = '0;
    wr(A_ENC, 64'hFF);

    // R7 preset beats increment
    wr(A_TYP, 64'h0);
    wr(A_ENS, 64'h01);
    wr(A_GCTL, 64'h1);
    wr(A_CNT, 64'd100);
    wr(A_GCTL, 64'h0);
    rd(A_CNT, v); chk("R7 write wins then one count", v, 64'd101);
    wr(A_ENC, 64'hFF);

    // R8 / R9 wrap and interrupt
    wr(A_CNT + 12'h18, 64'hFFFF_FFFF_FFFF_FFFE);
    wr(A_TYP + 12'h18, 64'h00);
    wr(A_ENS, 64'h08);
    wr(A_IES, 64'h08);
    run(1);
    rd(A_CNT + 12'h18, v); chk("R8 wrapped to zero", v, 64'h0);
    rd(A_OVS, v); chk("R8 overflow bit", v, 64'h08);
    chk("R9 irq set", 64'(irq), 64'h1);
    wr(A_IEC, 64'h08);
    #0.1 chk("R9 irq masked", 64'(irq), 64'h0);
    wr(A_IES, 64'h08);
    #0.1 chk("R9 irq unmasked", 64'(irq), 64'h1);
    wr(A_OVS, 64'h00);
    rd(A_OVS, v); chk("R8 zero write no effect", v, 64'h08);
    wr(A_OVS, 64'h08);
    rd(A_OVS, v); chk("R8 ack clears", v, 64'h0);
    chk("R9 irq drops", 64'(irq), 64'h0);
    wr(A_ENC, 64'hFF);

    // R8 wrap and acknowledge at one edge
    wr(A_TYP + 12'h28, 64'h09);
    wr(A_CNT + 12'h28, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(A_ENS, 64'h20);
    wr(A_GCTL, 64'h1);
    events[9] = 1'b1;
    wr(A_OVS, 64'h20);
    events[9] = 1'b0;
    wr(A_GCTL, 64'h0);
    rd(A_OVS, v); chk("R8 set wins over clear", v, 64'h20);
    rd(A_CNT + 12'h28, v); chk("R8 same-edge count", v, 64'h0);

    // R10 software reset
    wr(A_ENS, 64'hFF);
    wr(A_IES, 64'hFF);
    wr(A_CNT + 12'h30, 64'h55);
    wr(A_GCTL, 64'h2);
    rd(A_CNT + 12'h30, v); chk("R10 counter cleared", v, 64'h0);
    rd(A_CNT + 12'h00, v); chk("R10 counter0 cleared", v, 64'h0);
    rd(A_ENS, v);  chk("R10 enables cleared", v, 64'h0);
    rd(A_IES, v);  chk("R10 int enables cleared", v, 64'h0);
    rd(A_OVS, v);  chk("R10 overflow cleared", v, 64'h0);
    chk("R10 irq low", 64'(irq), 64'h0);
    rd(A_TYP + 12'h28, v); chk("R10 codes kept", v, 64'h09);
    wr(A_GCTL, 64'h3);
    rd(A_GCTL, v); chk("R10 reset bit reads zero", v, 64'h1);
    wr(A_GCTL, 64'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule